// File: doc/BRIEF.md
# Sub-word Write Coalescing Bridge

This bridge sits in front of a register file that accepts only aligned 32-bit accesses. Upstream it takes 8, 16 or 32-bit reads and writes with a byte address. Downstream it issues only whole-word accesses. A narrow read fetches the containing word and returns the addressed lane, zero-extended. A narrow write to an ordinary register becomes a read-modify-write of the containing word.

The four halfwords that set up a transfer get special handling, because back-to-back downstream writes to one word can lose data when the card clock is slow. Block-size and block-count writes are merged into a block shadow word. Transfer-mode writes are merged into a command shadow word. None of these three is sent downstream. When the command halfword is written, the bridge first writes a nonzero block shadow as one word and clears it. It then writes the command shadow, with the command merged in, as a second word.

When a low-speed input is set, every downstream write is followed by a programmable number of idle system clocks. This wait comes before the next access and before the upstream request is acknowledged.

Top module: `subword_bridge`

## Requirements
- R1: Every downstream access uses the byte address with its two low bits cleared. The request and its address stay stable from the cycle `dn_req` rises until the cycle `dn_ack` is seen.
- R2: An upstream read of size byte (`up_size`=0) or halfword (`up_size`=1) fetches one word. It returns the word shifted right by eight times the low two address bits, masked to 0xFF or 0xFFFF. A word read (`up_size`=2) returns the word unchanged.
- R3: A byte write, or a halfword write to any address other than 0x04, 0x06, 0x0C and 0x0E, makes exactly one downstream read and then one write to the same word. The write changes only the addressed lane.
- R4: A word write issues exactly one downstream write of the upstream data, with no read, and leaves both shadow words unchanged.
- R5: Halfword writes to 0x04 (low half) and 0x06 (high half) update the block shadow and cause no downstream access.
- R6: A halfword write to 0x0C updates the low half of the command shadow and causes no downstream access.
- R7: A halfword write to 0x0E first writes a nonzero block shadow to word 0x04 and then clears it. It then writes word 0x0C with the command shadow, with the command in bits 31:16. The order is always block word first.
- R8: The command shadow keeps its value after a command write. A command write that finds a zero block shadow issues only the word 0x0C write.
- R9: After reset both shadows are zero, and `up_ready` and `dn_req` are low.
- R10: While `slow_mode` is high, at least `gap_cycles` system clocks pass after each downstream write is acknowledged before the next `dn_req` rise, and before `up_ready`.
- R11: While `slow_mode` is low, no wait is inserted. The two words of a command flush are committed fewer than 8 cycles apart.
- R12: `up_ready` is a one-cycle pulse, given once per request. For reads, `up_rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_mode | input | 1 | Enables the post-write wait |
| gap_cycles | input | GW | Wait length in system clocks |
| up_valid | input | 1 | Upstream request, held until up_ready |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 0 byte, 1 halfword, 2 word |
| up_addr | input | AW | Upstream byte address |
| up_wdata | input | DW | Write data, narrow values in the low bits |
| up_ready | output | 1 | Request completion pulse |
| up_rdata | output | DW | Read result, zero-extended |
| dn_req | output | 1 | Downstream access request |
| dn_write | output | 1 | Downstream direction |
| dn_addr | output | AW | Word-aligned downstream address |
| dn_wdata | output | DW | Downstream write word |
| dn_ack | input | 1 | Downstream completion |
| dn_rdata | input | DW | Downstream read word, valid with dn_ack |

## Verification
Two functions can coincide in one cycle: the gap timer expiring, and the release of the second word of a command flush. If the block word's wait and the command word's issue were merged incorrectly, the command word would go out early or be lost. The bench provokes this with a nonzero block shadow in slow mode, then in fast mode. In both cases it judges the order, address and value of the two committed words and the spacing between their commit cycles. A command write with an empty block shadow checks that no stray block write appears.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DECODE,
    ST_RD,
    ST_RMW_RD,
    ST_WR,
    ST_BLK_WR,
    ST_CMD_ISSUE,
    ST_CMD_WR,
    ST_GAP,
    ST_DONE
  } state_e;
endpackage

// File: rtl/bridge_lane.sv
module bridge_lane
  import bridge_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 2
) (
  input  logic [DW-1:0] base,
  input  logic [LW-1:0] lane,
  input  logic [1:0]    size,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] extract,
  output logic [DW-1:0] merged
);
  localparam int SW = $clog2(DW);

  logic [SW-1:0] shift;
  logic [DW-1:0] mask;

  always_comb begin
    shift = SW'({lane, 3'b000});
    case (size)
      SZ_BYTE: mask = DW'(8'hFF);
      SZ_HALF: mask = DW'(16'hFFFF);
      default: mask = '1;
    endcase
    extract = (base >> shift) & mask;
    merged  = (base & ~(mask << shift)) | ((wdata & mask) << shift);
  end
endmodule

// File: rtl/bridge_shadows.sv
module bridge_shadows #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blk_we,
  input  logic          blk_clr,
  input  logic [DW-1:0] blk_val,
  input  logic          cmd_we,
  input  logic [DW-1:0] cmd_val,
  output logic [DW-1:0] blk_sh,
  output logic [DW-1:0] cmd_sh
);
  always_ff @(posedge clk) begin
    if (rst) begin
      blk_sh <= '0;
      cmd_sh <= '0;
    end else begin
      if (blk_clr)     blk_sh <= '0;
      else if (blk_we) blk_sh <= blk_val;
      if (cmd_we)      cmd_sh <= cmd_val;
    end
  end
endmodule

// File: rtl/bridge_gap_timer.sv
module bridge_gap_timer #(
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [GW-1:0] load_val,
  output logic          expired
);
  logic [GW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/subword_bridge.sv
module subword_bridge
  import bridge_pkg::*;
#(
  parameter int          AW          = 8,
  parameter int          DW          = 32,
  parameter int          GW          = 16,
  parameter logic [7:0]  OFF_BSIZE   = 8'h04,
  parameter logic [7:0]  OFF_BCOUNT  = 8'h06,
  parameter logic [7:0]  OFF_XMODE   = 8'h0C,
  parameter logic [7:0]  OFF_CMD     = 8'h0E
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slow_mode,
  input  logic [GW-1:0] gap_cycles,
  input  logic          up_valid,
  input  logic          up_write,
  input  logic [1:0]    up_size,
  input  logic [AW-1:0] up_addr,
  input  logic [DW-1:0] up_wdata,
  output logic          up_ready,
  output logic [DW-1:0] up_rdata,
  output logic          dn_req,
  output logic          dn_write,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  input  logic          dn_ack,
  input  logic [DW-1:0] dn_rdata
);
  localparam int LANES = DW / 8;
  localparam int LW    = $clog2(LANES);
  localparam logic [AW-1:0] A_BSIZE  = AW'(OFF_BSIZE);
  localparam logic [AW-1:0] A_BCOUNT = AW'(OFF_BCOUNT);
  localparam logic [AW-1:0] A_XMODE  = AW'(OFF_XMODE);
  localparam logic [AW-1:0] A_CMD    = AW'(OFF_CMD);
  localparam logic [AW-1:0] ALIGN    = ~AW'(LANES - 1);

  state_e        state, ret_state;
  logic          req_wr;
  logic [1:0]    req_size;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;

  logic [AW-1:0] word_addr;
  logic          is_half, is_blk, is_xfer, is_cmd;
  logic [DW-1:0] lane_base, lane_ext, lane_mrg;
  logic [DW-1:0] blk_sh, cmd_sh;
  logic          blk_we, blk_clr, cmd_we;
  logic          tmr_load, tmr_done;
  logic          wr_state;

  always_comb begin
    word_addr = req_addr & ALIGN;
    is_half   = (req_size == SZ_HALF);
    is_blk    = is_half && (req_addr == A_BSIZE || req_addr == A_BCOUNT);
    is_xfer   = is_half && (req_addr == A_XMODE);
    is_cmd    = is_half && (req_addr == A_CMD);
    if (state == ST_RD || state == ST_RMW_RD) lane_base = dn_rdata;
    else if (is_blk)                          lane_base = blk_sh;
    else                                      lane_base = cmd_sh;
    blk_we   = (state == ST_DECODE) && req_wr && is_blk;
    blk_clr  = (state == ST_DECODE) && req_wr && is_cmd && (blk_sh != '0);
    cmd_we   = ((state == ST_DECODE) && req_wr && is_xfer) || (state == ST_CMD_ISSUE);
    wr_state = (state == ST_WR) || (state == ST_BLK_WR) || (state == ST_CMD_WR);
    tmr_load = wr_state && dn_ack;
  end

  bridge_lane #(.DW(DW), .LW(LW)) u_lane (
    .base    (lane_base),
    .lane    (req_addr[LW-1:0]),
    .size    (req_size),
    .wdata   (req_wdata),
    .extract (lane_ext),
    .merged  (lane_mrg)
  );

  bridge_shadows #(.DW(DW)) u_shadows (
    .clk     (clk),
    .rst     (rst),
    .blk_we  (blk_we),
    .blk_clr (blk_clr),
    .blk_val (lane_mrg),
    .cmd_we  (cmd_we),
    .cmd_val (lane_mrg),
    .blk_sh  (blk_sh),
    .cmd_sh  (cmd_sh)
  );

  bridge_gap_timer #(.GW(GW)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (slow_mode ? gap_cycles : '0),
    .expired  (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ret_state <= ST_DONE;
      req_wr    <= 1'b0;
      req_size  <= '0;
      req_addr  <= '0;
      req_wdata <= '0;
      up_ready  <= 1'b0;
      up_rdata  <= '0;
      dn_req    <= 1'b0;
      dn_write  <= 1'b0;
      dn_addr   <= '0;
      dn_wdata  <= '0;
    end else begin
      up_ready <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (up_valid && !up_ready) begin
            req_wr    <= up_write;
            req_size  <= up_size;
            req_addr  <= up_addr;
            req_wdata <= up_wdata;
            state     <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          if (!req_wr) begin
            dn_req   <= 1'b1;
            dn_write <= 1'b0;
            dn_addr  <= word_addr;
            state    <= ST_RD;
          end else if (req_size != SZ_BYTE && req_size != SZ_HALF) begin
            dn_req   <= 1'b1;
            dn_write <= 1'b1;
            dn_addr  <= word_addr;
            dn_wdata <= req_wdata;
            state    <= ST_WR;
          end else if (is_blk || is_xfer) begin
            state <= ST_DONE;
          end else if (is_cmd) begin
            if (blk_sh != '0) begin
              dn_req   <= 1'b1;
              dn_write <= 1'b1;
              dn_addr  <= A_BSIZE & ALIGN;
              dn_wdata <= blk_sh;
              state    <= ST_BLK_WR;
            end else begin
              state <= ST_CMD_ISSUE;
            end
          end else begin
            dn_req   <= 1'b1;
            dn_write <= 1'b0;
            dn_addr  <= word_addr;
            state    <= ST_RMW_RD;
          end
        end
        ST_RD: begin
          if (dn_ack) begin
            dn_req   <= 1'b0;
            up_rdata <= lane_ext;
            state    <= ST_DONE;
          end
        end
        ST_RMW_RD: begin
          if (dn_ack) begin
            dn_write <= 1'b1;
            dn_wdata <= lane_mrg;
            state    <= ST_WR;
          end
        end
        ST_CMD_ISSUE: begin
          dn_req   <= 1'b1;
          dn_write <= 1'b1;
          dn_addr  <= A_XMODE & ALIGN;
          dn_wdata <= lane_mrg;
          state    <= ST_CMD_WR;
        end
        ST_WR, ST_CMD_WR, ST_BLK_WR: begin
          if (dn_ack) begin
            dn_req    <= 1'b0;
            ret_state <= (state == ST_BLK_WR) ? ST_CMD_ISSUE : ST_DONE;
            state     <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tmr_done) state <= ret_state;
        end
        ST_DONE: begin
          up_ready <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int GW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          slow_mode,
  input logic [GW-1:0] gap_cycles,
  input logic          up_ready,
  input logic          dn_req,
  input logic          dn_ack,
  input logic          dn_write,
  input logic [AW-1:0] dn_addr,
  input logic [DW-1:0] dn_wdata
);
  logic [GW:0] since_wr;
  logic        armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_wr <= '0;
      armed    <= 1'b0;
    end else if (dn_req && dn_ack && dn_write) begin
      since_wr <= '0;
      armed    <= 1'b1;
    end else if (since_wr != '1) begin
      since_wr <= since_wr + 1'b1;
    end
  end

  a_r1_word_aligned: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> dn_addr[1:0] == 2'b00);

  a_r1_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (dn_req && !dn_ack) |=> (dn_req && $stable(dn_addr) && $stable(dn_write) && $stable(dn_wdata)));

  a_r12_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    up_ready |=> !up_ready);

  a_r12_idle_at_ready: assert property (@(posedge clk) disable iff (rst)
    up_ready |-> !dn_req);

  a_r10_gap_before_req: assert property (@(posedge clk) disable iff (rst)
    (slow_mode && armed && $rose(dn_req)) |-> since_wr >= {1'b0, gap_cycles});

  a_r10_gap_before_ready: assert property (@(posedge clk) disable iff (rst)
    (slow_mode && armed && $rose(up_ready)) |-> since_wr >= {1'b0, gap_cycles});
endmodule

bind subword_bridge bridge_checker #(.AW(AW), .DW(DW), .GW(GW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .slow_mode  (slow_mode),
  .gap_cycles (gap_cycles),
  .up_ready   (up_ready),
  .dn_req     (dn_req),
  .dn_ack     (dn_ack),
  .dn_write   (dn_write),
  .dn_addr    (dn_addr),
  .dn_wdata   (dn_wdata)
);

// File: tb/subword_bridge_test.sv
`timescale 1ns/1ps
module subword_bridge_test;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int GW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          slow_mode = 1'b0;
  logic [GW-1:0] gap_cycles = '0;
  logic          up_valid = 1'b0;
  logic          up_write = 1'b0;
  logic [1:0]    up_size = '0;
  logic [AW-1:0] up_addr = '0;
  logic [DW-1:0] up_wdata = '0;
  logic          up_ready;
  logic [DW-1:0] up_rdata;
  logic          dn_req, dn_write;
  logic [AW-1:0] dn_addr;
  logic [DW-1:0] dn_wdata;
  logic          dn_ack = 1'b0;
  logic [DW-1:0] dn_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wcount = 0;
  int rcount = 0;
  logic [AW-1:0] wlog_addr [64];
  logic [DW-1:0] wlog_data [64];
  int            wlog_cyc  [64];
  logic [DW-1:0] mem [16];
  int            ready_cyc;
  logic [DW-1:0] rd_result;

  always #5 clk = ~clk;

  subword_bridge #(.AW(AW), .DW(DW), .GW(GW)) uut (
    .clk(clk), .rst(rst), .slow_mode(slow_mode), .gap_cycles(gap_cycles),
    .up_valid(up_valid), .up_write(up_write), .up_size(up_size),
    .up_addr(up_addr), .up_wdata(up_wdata), .up_ready(up_ready),
    .up_rdata(up_rdata), .dn_req(dn_req), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_ack(dn_ack),
    .dn_rdata(dn_rdata)
  );

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (dn_req && !dn_ack) begin
      dn_ack   <= 1'b1;
      dn_rdata <= mem[dn_addr[5:2]];
      if (dn_write) begin
        mem[dn_addr[5:2]]  <= dn_wdata;
        wlog_addr[wcount % 64] <= dn_addr;
        wlog_data[wcount % 64] <= dn_wdata;
        wlog_cyc[wcount % 64]  <= cyc;
        wcount <= wcount + 1;
      end else begin
        rcount <= rcount + 1;
      end
    end else begin
      dn_ack <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_cond(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [1:0] sz, input logic [AW-1:0] a,
                        input logic [DW-1:0] d);
    @(negedge clk);
    up_valid = 1'b1; up_write = wr; up_size = sz; up_addr = a; up_wdata = d;
    do @(negedge clk); while (!up_ready);
    rd_result = up_rdata;
    ready_cyc = cyc;
    up_valid  = 1'b0;
    @(negedge clk);
    if (up_ready) begin
      checks++; errors++;
      $display("FAIL R12 ready longer than one cycle actual=1 expected=0");
    end
  endtask

  task automatic t_reset;
    chk("R9 up_ready low after reset", 32'(up_ready), 32'd0);
    chk("R9 dn_req low after reset", 32'(dn_req), 32'd0);
    access(1'b1, 2'd1, 8'h0E, 32'h0000_0301);
    chk("R9 empty block shadow gives one write", 32'(wcount), 32'd1);
    chk("R9 command word with zero shadow", wlog_data[0], 32'h0301_0000);
    chk("R1 command word address", 32'(wlog_addr[0]), 32'h0C);
  endtask

  task automatic t_word;
    int w0, r0;
    w0 = wcount; r0 = rcount;
    access(1'b1, 2'd2, 8'h20, 32'hA5A5_1234);
    chk("R4 word write count", 32'(wcount - w0), 32'd1);
    chk("R4 word write no read", 32'(rcount - r0), 32'd0);
    chk("R4 word write data", mem[8], 32'hA5A5_1234);
    access(1'b0, 2'd2, 8'h20, '0);
    chk("R2 word read", rd_result, 32'hA5A5_1234);
  endtask

  task automatic t_narrow_read;
    access(1'b1, 2'd2, 8'h10, 32'h1122_3344);
    access(1'b0, 2'd0, 8'h13, '0);
    chk("R2 byte lane 3", rd_result, 32'h0000_0011);
    access(1'b0, 2'd0, 8'h10, '0);
    chk("R2 byte lane 0", rd_result, 32'h0000_0044);
    access(1'b0, 2'd1, 8'h12, '0);
    chk("R2 upper half", rd_result, 32'h0000_1122);
  endtask

  task automatic t_rmw;
    int w0, r0;
    w0 = wcount; r0 = rcount;
    access(1'b1, 2'd0, 8'h11, 32'h0000_0055);
    chk("R3 byte rmw one read", 32'(rcount - r0), 32'd1);
    chk("R3 byte rmw one write", 32'(wcount - w0), 32'd1);
    chk("R3 byte rmw result", mem[4], 32'h1122_5544);
    chk("R1 rmw aligned address", 32'(wlog_addr[w0 % 64]), 32'h10);
    access(1'b1, 2'd1, 8'h12, 32'h0000_BEEF);
    chk("R3 half rmw result", mem[4], 32'hBEEF_5544);
  endtask

  task automatic t_shadow_flush;
    int w0, r0;
    w0 = wcount; r0 = rcount;
    access(1'b1, 2'd1, 8'h04, 32'h0000_0200);
    access(1'b1, 2'd1, 8'h06, 32'h0000_0008);
    chk("R5 block halves send nothing", 32'((wcount - w0) + (rcount - r0)), 32'd0);
    access(1'b1, 2'd1, 8'h0C, 32'h0000_0013);
    chk("R6 transfer mode sends nothing", 32'((wcount - w0) + (rcount - r0)), 32'd0);
    access(1'b1, 2'd1, 8'h0E, 32'h0000_0C1A);
    chk("R7 flush writes two words", 32'(wcount - w0), 32'd2);
    chk("R7 first word is block address", 32'(wlog_addr[w0 % 64]), 32'h04);
    chk("R7 first word data", wlog_data[w0 % 64], 32'h0008_0200);
    chk("R7 second word is command address", 32'(wlog_addr[(w0 + 1) % 64]), 32'h0C);
    chk("R7 second word data", wlog_data[(w0 + 1) % 64], 32'h0C1A_0013);
    chk_cond("R11 fast flush spacing", (wlog_cyc[(w0 + 1) % 64] - wlog_cyc[w0 % 64]) < 8,
             wlog_cyc[(w0 + 1) % 64] - wlog_cyc[w0 % 64], 8);
  endtask

  task automatic t_retain;
    int w0;
    w0 = wcount;
    access(1'b1, 2'd1, 8'h0E, 32'h0000_0D00);
    chk("R8 cleared block shadow not resent", 32'(wcount - w0), 32'd1);
    chk("R8 transfer mode retained", wlog_data[w0 % 64], 32'h0D00_0013);
  endtask

  task automatic t_word_bypass;
    int w0;
    access(1'b1, 2'd1, 8'h04, 32'h0000_0010);
    w0 = wcount;
    access(1'b1, 2'd2, 8'h04, 32'hFFFF_FFFF);
    chk("R4 word write to block word passes", wlog_data[w0 % 64], 32'hFFFF_FFFF);
    access(1'b1, 2'd1, 8'h0E, 32'h0000_0E00);
    chk("R4 block shadow untouched by word write", wlog_data[(w0 + 1) % 64], 32'h0000_0010);
    chk("R4 command shadow untouched", wlog_data[(w0 + 2) % 64], 32'h0E00_0013);
  endtask

  task automatic t_slow;
    int w0, d;
    repeat (30) @(negedge clk);
    slow_mode = 1'b1; gap_cycles = 16'd20;
    access(1'b1, 2'd1, 8'h06, 32'h0000_0001);
    w0 = wcount;
    access(1'b1, 2'd1, 8'h0E, 32'h0000_0F00);
    chk("R10 slow flush writes two words", 32'(wcount - w0), 32'd2);
    chk("R7 slow flush block word", wlog_data[w0 % 64], 32'h0001_0000);
    chk("R7 slow flush command word", wlog_data[(w0 + 1) % 64], 32'h0F00_0013);
    d = wlog_cyc[(w0 + 1) % 64] - wlog_cyc[w0 % 64];
    chk_cond("R10 spacing between words", d >= 20, d, 20);
    d = ready_cyc - wlog_cyc[(w0 + 1) % 64];
    chk_cond("R10 wait before ready", d >= 20, d, 20);
    access(1'b1, 2'd2, 8'h30, 32'h0000_0777);
    d = ready_cyc - wlog_cyc[(wcount - 1) % 64];
    chk_cond("R10 wait after word write", d >= 20, d, 20);
    slow_mode = 1'b0;
    repeat (30) @(negedge clk);
    access(1'b1, 2'd2, 8'h30, 32'h0000_0888);
    d = ready_cyc - wlog_cyc[(wcount - 1) % 64];
    chk_cond("R11 no wait in fast mode", d < 8, d, 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_word();
    t_narrow_read();
    t_rmw();
    t_shadow_flush();
    t_retain();
    t_word_bypass();
    t_slow();
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule